// File: doc/BRIEF.md
# Scaled-Index Address Adder

This block is a purely combinational execution slice for a 64-bit core. It takes a 32-bit instruction word and the two source operand values. When the instruction is one of the scaled-index additions, it produces the result of shifting the first operand left by one, two or three places and adding the second operand. It also handles the word-indexed variants of those additions, an add whose first operand is zero-extended from 32 bits, and a shift-left immediate whose operand is zero-extended from 32 bits. For every other encoding it reports not-valid.

An issue stage presents the instruction and operands, and the result is ready in the same cycle. There is no flow control. The block has no state, so it neither stalls nor accepts back-pressure. A downstream mux uses the valid flag to decide whether this slice owns the result.

In the word-indexed forms, bits 63:32 of the first operand are forced to zero before it is shifted or added. The results are full 64-bit values that wrap on overflow and are never sign-extended.

Top module: `addr_calc_unit`

## Requirements
- R1: With opcode 0110011 and funct7 0000100's sibling 0010000 (bits 31:25), funct3 (bits 14:12) of 010, 100 or 110 selects a left shift of rs1 by 1, 2 or 3. The result is that shifted value plus rs2, and valid is 1.
- R2: With opcode 0111011, funct7 0010000 and the same three funct3 values, the result is computed as in R1, except that bits 63:32 of rs1 are taken as zero first.
- R3: With opcode 0111011, funct7 0000100 and funct3 000, the result is rs1 with bits 63:32 taken as zero, plus rs2, and valid is 1.
- R4: With opcode 0011011, bits 31:26 equal to 000010 and funct3 001, the result is rs1 with bits 63:32 taken as zero, shifted left by the 6-bit amount in bits 25:20. rs2 is not used.
- R5: Every result is the low 64 bits of the exact sum or shift. It wraps on overflow, and no sign extension is applied to any zero-extended form.
- R6: Under funct7 0010000 with opcode 0110011 or 0111011, any funct3 other than 010, 100 and 110 is not valid. This covers the reserved scale-by-16 slot.
- R7: Any encoding not listed in R1 to R4 gives valid 0 and a result of zero.
- R8: The rd field (bits 11:7) does not affect the outputs. In R4, the rs2 operand does not affect the outputs either.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| insn_i | input | 32 | Instruction word |
| rs1_i | input | 64 | First source operand (index) |
| rs2_i | input | 64 | Second source operand (base) |
| result_o | output | 64 | Computed result, zero when not valid |
| valid_o | output | 1 | Instruction recognised by this unit |

## Verification
The assertions assume that the instruction and operand inputs are settled whenever the combinational checks evaluate them. They therefore compare the outputs with the inputs of the same evaluation and never across time. The bench changes all inputs together, just after a rising edge, and reads the outputs well before the next edge, so no partial update is ever observed. The operand sets deliberately include values that have bit 31 set or nonzero upper halves. This makes the zero-extension and no-sign-extension checks meaningful.

// File: rtl/addr_calc_pkg.sv
package addr_calc_pkg;

  localparam int unsigned INSN_W = 32;

  localparam logic [6:0] OPC_REG    = 7'b0110011;
  localparam logic [6:0] OPC_REG_W  = 7'b0111011;
  localparam logic [6:0] OPC_IMM_W  = 7'b0011011;

  localparam logic [6:0] F7_SCALED  = 7'b0010000;
  localparam logic [6:0] F7_ZXADD   = 7'b0000100;
  localparam logic [5:0] TOP6_ZXSHL = 6'b000010;

  localparam logic [2:0] F3_SCALE1  = 3'b010;
  localparam logic [2:0] F3_SCALE2  = 3'b100;
  localparam logic [2:0] F3_SCALE3  = 3'b110;
  localparam logic [2:0] F3_ZXADD   = 3'b000;
  localparam logic [2:0] F3_ZXSHL   = 3'b001;

  typedef enum logic [1:0] {
    KIND_NONE   = 2'd0,
    KIND_SCALED = 2'd1,
    KIND_ZXADD  = 2'd2,
    KIND_ZXSHL  = 2'd3
  } op_kind_e;

  typedef struct packed {
    logic     hit;
    op_kind_e kind;
    logic     zext;
    logic     use_base;
    logic [5:0] shamt;
  } dec_ctrl_t;

endpackage

// File: rtl/addr_calc_decode.sv
module addr_calc_decode
  import addr_calc_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output dec_ctrl_t         ctrl
);
  logic [6:0] opc;
  logic [6:0] f7;
  logic [2:0] f3;
  logic [5:0] imm6;
  logic       unused_fields;

  assign opc  = insn[6:0];
  assign f3   = insn[14:12];
  assign f7   = insn[31:25];
  assign imm6 = insn[25:20];
  assign unused_fields = ^insn[19:7];

  logic [1:0] scale;
  logic       scale_ok;

  always_comb begin
    scale_ok = 1'b1;
    unique case (f3)
      F3_SCALE1: scale = 2'd1;
      F3_SCALE2: scale = 2'd2;
      F3_SCALE3: scale = 2'd3;
      default: begin
        scale    = 2'd0;
        scale_ok = 1'b0;
      end
    endcase
  end

  always_comb begin
    ctrl = '{hit: 1'b0, kind: KIND_NONE, zext: 1'b0, use_base: 1'b0, shamt: 6'd0};
    if ((opc == OPC_REG) && (f7 == F7_SCALED) && scale_ok) begin
      ctrl.hit      = 1'b1;
      ctrl.kind     = KIND_SCALED;
      ctrl.use_base = 1'b1;
      ctrl.shamt    = {4'd0, scale};
    end else if ((opc == OPC_REG_W) && (f7 == F7_SCALED) && scale_ok) begin
      ctrl.hit      = 1'b1;
      ctrl.kind     = KIND_SCALED;
      ctrl.zext     = 1'b1;
      ctrl.use_base = 1'b1;
      ctrl.shamt    = {4'd0, scale};
    end else if ((opc == OPC_REG_W) && (f7 == F7_ZXADD) && (f3 == F3_ZXADD)) begin
      ctrl.hit      = 1'b1;
      ctrl.kind     = KIND_ZXADD;
      ctrl.zext     = 1'b1;
      ctrl.use_base = 1'b1;
    end else if ((opc == OPC_IMM_W) && (insn[31:26] == TOP6_ZXSHL) && (f3 == F3_ZXSHL)) begin
      ctrl.hit      = 1'b1;
      ctrl.kind     = KIND_ZXSHL;
      ctrl.zext     = 1'b1;
      ctrl.shamt    = imm6;
    end
  end

endmodule

// File: rtl/addr_calc_operand.sv
module addr_calc_operand #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned WORD = 32
) (
  input  logic [XLEN-1:0] src,
  input  logic            zext,
  output logic [XLEN-1:0] opnd
);
  for (genvar i = 0; i < XLEN; i++) begin : g_bit
    if (i < WORD) begin : g_low
      assign opnd[i] = src[i];
    end else begin : g_high
      assign opnd[i] = src[i] & ~zext;
    end
  end
endmodule

// File: rtl/addr_calc_shadd.sv
module addr_calc_shadd #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned SHW  = 6
) (
  input  logic [XLEN-1:0] index,
  input  logic [XLEN-1:0] base,
  input  logic [SHW-1:0]  shamt,
  input  logic            use_base,
  input  logic            enable,
  output logic [XLEN-1:0] sum
);
  logic [XLEN-1:0] scaled;
  logic [XLEN-1:0] addend;

  assign scaled = index << shamt;
  assign addend = use_base ? base : '0;
  assign sum    = enable ? (scaled + addend) : '0;
endmodule

// File: rtl/addr_calc_unit.sv
module addr_calc_unit
  import addr_calc_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned WORD = 32
) (
  input  logic [INSN_W-1:0] insn_i,
  input  logic [XLEN-1:0]   rs1_i,
  input  logic [XLEN-1:0]   rs2_i,
  output logic [XLEN-1:0]   result_o,
  output logic              valid_o
);
  localparam int unsigned SHW = $clog2(XLEN);

  dec_ctrl_t       ctrl;
  logic [XLEN-1:0] index_op;
  logic [SHW-1:0]  shamt;

  addr_calc_decode u_dec (
    .insn (insn_i),
    .ctrl (ctrl)
  );

  addr_calc_operand #(.XLEN(XLEN), .WORD(WORD)) u_opnd (
    .src  (rs1_i),
    .zext (ctrl.zext),
    .opnd (index_op)
  );

  assign shamt = ctrl.shamt[SHW-1:0];

  addr_calc_shadd #(.XLEN(XLEN), .SHW(SHW)) u_sa (
    .index    (index_op),
    .base     (rs2_i),
    .shamt    (shamt),
    .use_base (ctrl.use_base),
    .enable   (ctrl.hit),
    .sum      (result_o)
  );

  assign valid_o = ctrl.hit;

endmodule

// File: rtl/addr_calc_unit_chk.sv
module addr_calc_unit_chk #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned WORD = 32
) (
  input logic [31:0]     insn_i,
  input logic [XLEN-1:0] rs1_i,
  input logic [XLEN-1:0] rs2_i,
  input logic [XLEN-1:0] result_o,
  input logic            valid_o
);
  logic [6:0] c_opc;
  logic [6:0] c_f7;
  logic [2:0] c_f3;
  logic [5:0] c_sh;
  logic       unused_rs1;

  assign c_opc = insn_i[6:0];
  assign c_f7  = insn_i[31:25];
  assign c_f3  = insn_i[14:12];
  assign c_sh  = insn_i[25:20];
  assign unused_rs1 = ^rs1_i;

  always_comb begin
    // R7: idle output is zero
    assert_idle_zero_R7: assert (valid_o || (result_o == '0));
    // R7: valid only for the three owned major opcodes
    assert_opcode_R7: assert (!valid_o || (c_opc == 7'b0110011) ||
                              (c_opc == 7'b0111011) || (c_opc == 7'b0011011));
    // R6: reserved scale slots are never accepted
    assert_reserved_R6: assert (!(((c_opc == 7'b0110011) || (c_opc == 7'b0111011)) &&
                                  (c_f7 == 7'b0010000) &&
                                  ((c_f3[0] == 1'b1) || (c_f3 == 3'b000))) || !valid_o);
    // R2: word-indexed scaled add with zero base stays inside WORD+3 bits
    assert_uw_upper_R2: assert (!(valid_o && (c_opc == 7'b0111011) &&
                                  (c_f7 == 7'b0010000) && (rs2_i == '0)) ||
                                ((result_o >> (WORD + 3)) == '0));
    // R4: zero-extended shift leaves the low shamt bits clear
    assert_shl_low_R4: assert (!(valid_o && (c_opc == 7'b0011011)) ||
                               ((result_o & ((64'd1 << c_sh) - 64'd1)) == '0));
    // R1: scaled add with zero base is even
    assert_scaled_lsb_R1: assert (!(valid_o && (c_opc == 7'b0110011) && (rs2_i == '0)) ||
                                  (result_o[0] == 1'b0));
  end
endmodule

bind addr_calc_unit addr_calc_unit_chk #(.XLEN(XLEN), .WORD(WORD)) u_chk (
  .insn_i   (insn_i),
  .rs1_i    (rs1_i),
  .rs2_i    (rs2_i),
  .result_o (result_o),
  .valid_o  (valid_o)
);

// File: tb/addr_calc_unit_test.sv
module addr_calc_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] insn = '0;
  logic [63:0] a = '0;
  logic [63:0] b = '0;
  logic [63:0] res;
  logic        vld;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  addr_calc_unit uut (
    .insn_i(insn), .rs1_i(a), .rs2_i(b), .result_o(res), .valid_o(vld)
  );

  function automatic logic [31:0] mk(input logic [6:0] f7, input logic [4:0] r2,
                                     input logic [4:0] r1, input logic [2:0] f3,
                                     input logic [4:0] rd, input logic [6:0] opc);
    return {f7, r2, r1, f3, rd, opc};
  endfunction

  function automatic logic [64:0] model(input logic [31:0] i, input logic [63:0] x,
                                        input logic [63:0] y);
    logic [63:0] xz;
    xz = {32'd0, x[31:0]};
    if (i[31:25] == 7'b0010000 && (i[6:0] == 7'b0110011 || i[6:0] == 7'b0111011)) begin
      logic [63:0] src;
      src = (i[6:0] == 7'b0111011) ? xz : x;
      case (i[14:12])
        3'b010: return {1'b1, (src * 64'd2) + y};
        3'b100: return {1'b1, (src * 64'd4) + y};
        3'b110: return {1'b1, (src * 64'd8) + y};
        default: return 65'd0;
      endcase
    end
    if (i[6:0] == 7'b0111011 && i[31:25] == 7'b0000100 && i[14:12] == 3'b000)
      return {1'b1, xz + y};
    if (i[6:0] == 7'b0011011 && i[31:26] == 6'b000010 && i[14:12] == 3'b001)
      return {1'b1, xz * (64'd1 << i[25:20])};
    return 65'd0;
  endfunction

  task automatic apply(input logic [31:0] i, input logic [63:0] x, input logic [63:0] y);
    @(posedge clk);
    #1;
    insn = i; a = x; b = y;
    #2;
  endtask

  task automatic expect_out(input string tag, input logic ev, input logic [63:0] er);
    total++;
    if (vld !== ev || res !== er) begin
      bad++;
      $display("FAIL %s insn=%h rs1=%h rs2=%h actual=%b/%h expected=%b/%h",
               tag, insn, a, b, vld, res, ev, er);
    end
  endtask

  task automatic run(input string tag, input logic [31:0] i, input logic [63:0] x,
                     input logic [63:0] y);
    logic [64:0] e;
    apply(i, x, y);
    e = model(i, x, y);
    expect_out(tag, e[64], e[63:0]);
  endtask

  logic [63:0] vals [8];
  initial begin
    vals[0] = 64'd0;                  vals[1] = 64'd1;
    vals[2] = 64'h0000_0000_7FFF_FFFF; vals[3] = 64'h0000_0000_8000_0000;
    vals[4] = 64'h0000_0000_FFFF_FFFF; vals[5] = 64'h0000_0001_0000_0000;
    vals[6] = 64'hDEAD_BEEF_8000_0001; vals[7] = 64'hFFFF_FFFF_FFFF_FFFF;
  end

  initial begin
    logic [2:0] scl [3];
    logic [31:0] lfsr;
    scl[0] = 3'b010; scl[1] = 3'b100; scl[2] = 3'b110;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R7: all-zero instruction is not owned
    apply(32'd0, 64'd5, 64'd7);
    expect_out("R7 idle", 1'b0, 64'd0);
    // R1 and R2: scaled adds over operand grid
    for (int s = 0; s < 3; s++)
      for (int p = 0; p < 8; p++)
        for (int q = 0; q < 8; q++) begin
          run("R1", mk(7'b0010000, 5'd3, 5'd4, scl[s], 5'd5, 7'b0110011), vals[p], vals[q]);
          run("R2", mk(7'b0010000, 5'd3, 5'd4, scl[s], 5'd5, 7'b0111011), vals[p], vals[q]);
        end
    // R2: explicit value with upper bits and bit 31 set
    apply(mk(7'b0010000, 5'd1, 5'd2, 3'b110, 5'd3, 7'b0111011), 64'hDEAD_BEEF_8000_0001, 64'd0);
    expect_out("R2 explicit", 1'b1, 64'h0000_0004_0000_0008);
    // R3: zero-extended add
    for (int p = 0; p < 8; p++)
      for (int q = 0; q < 8; q++)
        run("R3", mk(7'b0000100, 5'd9, 5'd8, 3'b000, 5'd1, 7'b0111011), vals[p], vals[q]);
    // R4: every shift amount
    for (int sh = 0; sh < 64; sh++)
      for (int p = 2; p < 8; p++)
        run("R4", {6'b000010, sh[5:0], 5'd6, 3'b001, 5'd2, 7'b0011011}, vals[p], vals[7]);
    apply({6'b000010, 6'd63, 5'd6, 3'b001, 5'd2, 7'b0011011}, 64'hFFFF_FFFF_0000_0001, 64'd9);
    expect_out("R4 top shift", 1'b1, 64'h8000_0000_0000_0000);
    // R5: wraparound and no sign extension
    apply(mk(7'b0010000, 5'd1, 5'd2, 3'b110, 5'd3, 7'b0110011), 64'hFFFF_FFFF_FFFF_FFFF,
          64'hFFFF_FFFF_FFFF_FFFF);
    expect_out("R5 wrap", 1'b1, 64'hFFFF_FFFF_FFFF_FFF7);
    apply(mk(7'b0000100, 5'd1, 5'd2, 3'b000, 5'd3, 7'b0111011), 64'hFFFF_FFFF_FFFF_FFFF, 64'd1);
    expect_out("R5 no sext", 1'b1, 64'h0000_0001_0000_0000);
    // R6: reserved scale slots
    for (int f = 0; f < 8; f++) begin
      if (f == 2 || f == 4 || f == 6) continue;
      apply(mk(7'b0010000, 5'd1, 5'd2, f[2:0], 5'd3, 7'b0110011), vals[6], vals[6]);
      expect_out("R6", 1'b0, 64'd0);
      apply(mk(7'b0010000, 5'd1, 5'd2, f[2:0], 5'd3, 7'b0111011), vals[6], vals[6]);
      expect_out("R6 uw", 1'b0, 64'd0);
    end
    // R4 slot neighbour: bit 26 set is not owned
    apply({6'b000011, 6'd4, 5'd6, 3'b001, 5'd2, 7'b0011011}, 64'd3, 64'd0);
    expect_out("R7 bit26", 1'b0, 64'd0);
    // R8: rd field and rs2 in shift form have no effect
    for (int rd = 0; rd < 32; rd += 7) begin
      apply(mk(7'b0010000, 5'd1, 5'd2, 3'b100, rd[4:0], 7'b0110011), 64'd10, 64'd3);
      expect_out("R8 rd", 1'b1, 64'd43);
      apply({6'b000010, 6'd4, 5'd6, 3'b001, rd[4:0], 7'b0011011}, 64'h1_0000_0003,
            64'hFFFF_0000_1234_5678 ^ {32'd0, rd});
      expect_out("R8 rs2", 1'b1, 64'd48);
    end
    // R7: pseudo-random instruction words against the model
    lfsr = 32'hACE1_1234;
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      run("R7 random", (n % 2 == 0) ? {lfsr[31:7], 7'b0111011} : lfsr,
          {lfsr, ~lfsr}, {~lfsr, lfsr});
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule